// File: doc/BRIEF.md
# Phase-Lock Detector with Consecutive-Cycle Qualification

This block decides whether a phase-locked loop has settled. Once per reference cycle it receives a measured phase-error magnitude, expressed in periods of a fast timing clock, from the circuitry that times the phase detector's up and down pulses. A cycle is accepted when that magnitude does not exceed the chosen precision window. The block counts accepted cycles in an unbroken run. It raises its lock output when the run reaches the chosen length.

Two inputs select the behaviour. One sets the run length to 3072 or 2048 cycles. The other sets the window to a coarse 16 ns or a fine 6 ns; with the default 1 GHz timing clock these are 16 and 6 ticks. A strobe marks the start of a new acquisition. It empties the run and pulls the lock output low at once. An enable input gates the whole function, and the lock output stays low while the enable is low.

Top module: `pll_lock_detect`

## Requirements
- R1: During and directly after synchronous reset, `lock_o` is 0 and the run count is empty.
- R2: While `det_en_i` is 0, `lock_o` is 0 on the next cycle and the run count is held empty. Samples presented while disabled do not count once the block is enabled again.
- R3: With `len_sel_i` = 0, `lock_o` rises on the clock edge that takes in the 3072nd consecutive accepted sample, and not before.
- R4: With `len_sel_i` = 1, `lock_o` rises on the clock edge that takes in the 2048th consecutive accepted sample, and not before.
- R5: With `fine_sel_i` = 0 (coarse), a sample is accepted when `err_mag_i` <= 16.
- R6: With `fine_sel_i` = 1 (fine), a sample is accepted when `err_mag_i` <= 6.
- R7: An `acq_start_i` pulse empties the run and makes `lock_o` 0 on the next cycle. It takes precedence over a sample presented in the same cycle, which is then not counted.
- R8: A rejected sample (`err_valid_i` = 1, magnitude outside the window) empties the run and makes `lock_o` 0 on the next cycle.
- R9: The run count saturates at the selected length. `lock_o` stays 1 for any number of further accepted samples.
- R10: A change of `len_sel_i` or `fine_sel_i` empties the run and makes `lock_o` 0 on the next cycle. The sample in that cycle is not counted.
- R11: Cycles with `err_valid_i` = 0 neither advance nor empty the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en_i | input | 1 | Enables lock detection |
| len_sel_i | input | 1 | Run length: 0 = 3072, 1 = 2048 |
| fine_sel_i | input | 1 | Window: 0 = coarse (16), 1 = fine (6) |
| acq_start_i | input | 1 | One-cycle strobe marking a new acquisition |
| err_valid_i | input | 1 | A phase-error sample is present this cycle |
| err_mag_i | input | 8 | Phase-error magnitude in timing-clock ticks |
| lock_o | output | 1 | 1 = locked, 0 = not locked |

## Verification
The embedded properties check every cycle that an acquisition strobe, a rejected sample, a disable or a selection change leaves the output low on the next cycle. They also check that idle cycles leave the count unchanged and that the count never passes the selected length while the selection is steady. The exact lock edges belong to the bench: the rise on the 3072nd or 2048th accepted sample, and the acceptance boundaries at 16/17 and 6/7. So do the cases that depend on history: no wrap after thousands of extra samples, and samples taken while disabled not counting.

// File: rtl/ld_pkg.sv
// Package ld_pkg
// Shared types for the lock detector: the action the run counter takes
// in a given cycle. Assumes nothing beyond IEEE 1800-2017.
package ld_pkg;
    typedef enum logic [1:0] {
        LD_HOLD  = 2'd0,
        LD_CLEAR = 2'd1,
        LD_STEP  = 2'd2
    } ld_act_e;
endpackage

// File: rtl/ld_window_cmp.sv
// Module ld_window_cmp
// Decides whether a phase-error magnitude lies inside the selected window.
// Assumes the magnitude is already an unsigned count of timing-clock ticks.
module ld_window_cmp #(
    parameter int MAG_W      = 8,
    parameter int COARSE_WIN = 16,
    parameter int FINE_WIN   = 6
) (
    input  logic             fine_sel_i,
    input  logic [MAG_W-1:0] err_mag_i,
    output logic             in_win_o
);
    localparam logic [MAG_W-1:0] COARSE_LIM = MAG_W'(COARSE_WIN);
    localparam logic [MAG_W-1:0] FINE_LIM   = MAG_W'(FINE_WIN);

    logic [MAG_W-1:0] win_lim;

    // Pick the window limit and compare inclusively.
    always_comb begin
        win_lim  = fine_sel_i ? FINE_LIM : COARSE_LIM;
        in_win_o = (err_mag_i <= win_lim);
    end
endmodule

// File: rtl/ld_ctrl.sv
// Module ld_ctrl
// Turns enable, acquisition strobe, selection changes and sample quality
// into one counter action per cycle. The restart conditions take precedence
// over any sample in the same cycle. Assumes the selects come from the same clock.
module ld_ctrl
    import ld_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    det_en_i,
    input  logic    len_sel_i,
    input  logic    fine_sel_i,
    input  logic    acq_start_i,
    input  logic    err_valid_i,
    input  logic    in_win_i,
    output ld_act_e act_o,
    output logic    sel_chg_o
);
    logic len_sel_q;
    logic fine_sel_q;

    // Remember the previous selects; during reset they follow the inputs.
    always_ff @(posedge clk) begin
        len_sel_q  <= len_sel_i;
        fine_sel_q <= fine_sel_i;
    end

    // Detect a selection change relative to the previous cycle.
    always_comb begin
        sel_chg_o = (len_sel_i != len_sel_q) || (fine_sel_i != fine_sel_q);
    end

    // Choose the counter action with restart conditions first.
    always_comb begin
        if (!rst_n || !det_en_i || acq_start_i || sel_chg_o) begin
            act_o = LD_CLEAR;
        end else if (err_valid_i && in_win_i) begin
            act_o = LD_STEP;
        end else if (err_valid_i) begin
            act_o = LD_CLEAR;
        end else begin
            act_o = LD_HOLD;
        end
    end
endmodule

// File: rtl/ld_run_counter.sv
// Module ld_run_counter
// Saturating counter of consecutive accepted samples. It exposes both the
// registered count and the next-state value so that the lock flag can be
// updated on the same edge. Assumes lim_i never exceeds the counter range.
module ld_run_counter
    import ld_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ld_act_e       act_i,
    input  logic [CW-1:0] lim_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o
);
    logic [CW-1:0] cnt_q;

    // Compute the next count: clear, hold, or step with saturation.
    always_comb begin
        unique case (act_i)
            LD_CLEAR: cnt_nxt_o = '0;
            LD_STEP:  cnt_nxt_o = (cnt_q >= lim_i) ? lim_i : cnt_q + 1'b1;
            default:  cnt_nxt_o = cnt_q;
        endcase
    end

    // Register the count; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt_o;
        end
    end

    assign cnt_o = cnt_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == LD_HOLD) |=> (cnt_q == $past(cnt_q)))
        else $error("counter moved on an idle cycle"); // R11

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == LD_CLEAR) |=> (cnt_q == '0))
        else $error("counter not empty after clear"); // R7
endmodule

// File: rtl/pll_lock_detect.sv
// Module pll_lock_detect
// Lock detector: counts consecutive in-window phase-error samples and
// holds lock_o high once the selected run length is reached. Assumes one
// err_valid_i pulse per reference cycle, synchronous to clk.
module pll_lock_detect
    import ld_pkg::*;
#(
    parameter int MAG_W      = 8,
    parameter int COARSE_WIN = 16,
    parameter int FINE_WIN   = 6,
    parameter int LONG_RUN   = 3072,
    parameter int SHORT_RUN  = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en_i,
    input  logic             len_sel_i,
    input  logic             fine_sel_i,
    input  logic             acq_start_i,
    input  logic             err_valid_i,
    input  logic [MAG_W-1:0] err_mag_i,
    output logic             lock_o
);
    localparam int CW = $clog2(((LONG_RUN > SHORT_RUN) ? LONG_RUN : SHORT_RUN) + 1);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_RUN);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_RUN);

    logic          in_win;
    logic          sel_chg;
    ld_act_e       act;
    logic [CW-1:0] run_lim;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          lock_q;

    ld_window_cmp #(
        .MAG_W      (MAG_W),
        .COARSE_WIN (COARSE_WIN),
        .FINE_WIN   (FINE_WIN)
    ) u_win (
        .fine_sel_i (fine_sel_i),
        .err_mag_i  (err_mag_i),
        .in_win_o   (in_win)
    );

    ld_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_en_i    (det_en_i),
        .len_sel_i   (len_sel_i),
        .fine_sel_i  (fine_sel_i),
        .acq_start_i (acq_start_i),
        .err_valid_i (err_valid_i),
        .in_win_i    (in_win),
        .act_o       (act),
        .sel_chg_o   (sel_chg)
    );

    // Select the run length that qualifies lock.
    always_comb begin
        run_lim = len_sel_i ? SHORT_LIM : LONG_LIM;
    end

    ld_run_counter #(
        .CW (CW)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .lim_i     (run_lim),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt)
    );

    // Update the lock flag on the same edge the count reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= (cnt_nxt == run_lim);
        end
    end

    assign lock_o = lock_q;

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en_i |=> !lock_o)
        else $error("lock high while disabled"); // R2

    AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start_i |=> (!lock_o && cnt == '0))
        else $error("acquisition start did not drop lock"); // R7

    AST_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid_i && !in_win) |=> !lock_o)
        else $error("rejected sample did not drop lock"); // R8

    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (!lock_o && cnt == '0))
        else $error("selection change did not restart"); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_chg |-> (cnt <= run_lim))
        else $error("count beyond run length"); // R9

    AST_LOCK_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !sel_chg) |-> (cnt == run_lim))
        else $error("lock high below run length"); // R3
endmodule

// File: tb/pll_lock_detect_bench.sv
module pll_lock_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_en = 1'b0;
    logic       len_sel = 1'b0;
    logic       fine_sel = 1'b0;
    logic       acq_start = 1'b0;
    logic       err_valid = 1'b0;
    logic [7:0] err_mag = 8'd0;
    logic       lock;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_lock_detect u_pll_lock_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_en_i    (det_en),
        .len_sel_i   (len_sel),
        .fine_sel_i  (fine_sel),
        .acq_start_i (acq_start),
        .err_valid_i (err_valid),
        .err_mag_i   (err_mag),
        .lock_o      (lock)
    );

    // Window vectors: {fine_sel, expected acceptance, magnitude}.
    localparam logic [9:0] WIN_VEC [8] = '{
        {1'b0, 1'b1, 8'd0},
        {1'b0, 1'b1, 8'd16},
        {1'b0, 1'b0, 8'd17},
        {1'b0, 1'b0, 8'd255},
        {1'b1, 1'b1, 8'd3},
        {1'b1, 1'b1, 8'd6},
        {1'b1, 1'b0, 8'd7},
        {1'b1, 1'b0, 8'd16}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic samp(input logic [7:0] mag);
        err_valid = 1'b1;
        err_mag   = mag;
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    task automatic run(input int n, input logic [7:0] mag);
        for (int i = 0; i < n; i++) samp(mag);
    endtask

    task automatic start_acq();
        acq_start = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        check("R1 lock in reset", lock, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        det_en = 1'b1;
        idle(1);
        check("R1 lock after reset", lock, 0);

        // R5 R6: window table, run length 2048 (R4)
        len_sel = 1'b1;
        idle(2);
        for (int v = 0; v < 8; v++) begin
            fine_sel = WIN_VEC[v][9];
            idle(1);
            start_acq();
            run(2047, 8'd0);
            samp(WIN_VEC[v][7:0]);
            check(WIN_VEC[v][9] ? "R6 fine window" : "R5 coarse window",
                  lock, WIN_VEC[v][8]);
        end
        fine_sel = 1'b0;
        idle(1);

        // R4: exact edge at 2048
        start_acq();
        run(2047, 8'd5);
        check("R4 not yet at 2047", lock, 0);
        samp(8'd5);
        check("R4 lock at 2048", lock, 1);

        // R3: exact edge at 3072
        len_sel = 1'b0;
        idle(1);
        start_acq();
        run(3071, 8'd10);
        check("R3 not yet at 3071", lock, 0);
        samp(8'd10);
        check("R3 lock at 3072", lock, 1);

        // R9: saturation, no wrap
        run(5000, 8'd1);
        check("R9 still locked after 5000 extra", lock, 1);

        // R11: idle cycles keep lock and keep a partial run
        idle(10);
        check("R11 lock held over idle", lock, 1);
        len_sel = 1'b1;
        idle(1);
        start_acq();
        run(2047, 8'd0);
        idle(20);
        check("R11 partial run kept, still low", lock, 0);
        samp(8'd0);
        check("R11 partial run resumes", lock, 1);

        // R8: rejected sample drops lock and empties the run
        samp(8'd200);
        check("R8 lock dropped", lock, 0);
        run(2047, 8'd0);
        check("R8 run restarted from zero", lock, 0);
        samp(8'd0);
        check("R8 relock", lock, 1);

        // R7: start drops lock; sample in the same cycle is not counted
        acq_start = 1'b1;
        err_valid = 1'b1;
        err_mag   = 8'd0;
        @(negedge clk);
        acq_start = 1'b0;
        err_valid = 1'b0;
        check("R7 lock dropped on start", lock, 0);
        run(2047, 8'd0);
        check("R7 simultaneous sample ignored", lock, 0);
        samp(8'd0);
        check("R7 relock after start", lock, 1);

        // R2: disable drops lock; samples while disabled do not count
        det_en = 1'b0;
        idle(1);
        check("R2 lock dropped when disabled", lock, 0);
        run(3000, 8'd0);
        check("R2 no lock while disabled", lock, 0);
        det_en = 1'b1;
        run(2047, 8'd0);
        check("R2 disabled samples not counted", lock, 0);
        samp(8'd0);
        check("R2 lock after enable", lock, 1);

        // R10: precision change restarts
        fine_sel = 1'b1;
        idle(1);
        check("R10 lock dropped on precision change", lock, 0);
        run(2047, 8'd0);
        check("R10 run restarted (precision)", lock, 0);
        samp(8'd0);
        check("R10 relock (precision)", lock, 1);

        // R10: length change mid-run restarts with the new length
        start_acq();
        run(2047, 8'd0);
        len_sel = 1'b0;
        samp(8'd0);
        check("R10 lock low on length change", lock, 0);
        run(3071, 8'd0);
        check("R10 run restarted (length)", lock, 0);
        samp(8'd0);
        check("R10 relock at new length", lock, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule